// File: doc/BRIEF.md
# Saturating INT4 Lane Packer

The packer receives a stream of signed 32-bit integers over a valid/ready handshake. Each integer is clamped to the signed 4-bit range -8..7, and the low four bits of the clamped two's-complement value go into the next free nibble of a 32-bit word. A word holds eight such lanes. Each finished word leaves through a registered valid/ready output.

A word is finished either when its eighth lane is written or when the incoming value carries the last flag. When the last flag closes a word early, the lanes that were never written read as zero. The last flag is passed on with the word that it closes.

While a finished word waits at the output, the input is held off. Otherwise the block takes one value per clock.

Top module: `int4_lane_packer`

## Requirements
- R1: A value above 7 is stored as 7 (nibble 0x7), and a value below -8 is stored as -8 (nibble 0x8). Values within -8..7 are stored unchanged.
- R2: The stored nibble is the low 4 bits of the clamped two's-complement value, so -1 is stored as 0xF.
- R3: The k-th value of a word (k = 0..7, counted from the word's start) occupies out_word bits 4k+3:4k, so the first value is in bits 3:0.
- R4: After eight accepted values without a last flag, exactly one word is emitted, with out_last = 0.
- R5: An accepted value with in_last = 1 emits the partial word with out_last = 1, and every nibble above the written lanes is zero.
- R6: If the value that fills lane 7 carries in_last, exactly one word is emitted, and no empty word follows it.
- R7: A synchronous active-high reset clears out_valid, raises in_ready and discards any partial word, so the next value starts a new word at lane 0.
- R8: While out_valid = 1 and out_ready = 0, out_word and out_last hold steady and in_ready is 0.
- R9: While out_ready is held high, one value is accepted every cycle, with no bubble. in_ready is low only while a word is pending.
- R10: After a word is emitted, the next accepted value goes into lane 0 of a fresh, zeroed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value is present |
| in_ready | output | 1 | Packer can take the value this cycle |
| in_data | input | 32 | Signed integer to be packed |
| in_last | input | 1 | Value closes the current word |
| out_valid | output | 1 | Packed word is available |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 32 | Eight 4-bit lanes, lane 0 in bits 3:0 |
| out_last | output | 1 | Word was closed by a last-flagged value |

## Verification
The checker's lane count assumes that a value moves only in a cycle where in_valid and in_ready are both high, and that reset is held high at the first clock edge. out_ready may change freely from cycle to cycle. The bench holds each value and its last flag until the value is accepted, toggles out_ready at random outside the directed phase, and starts every run under reset. It also flags the final random value as last, so no partial word is left over when the reset case begins.

// File: rtl/int4pack_pkg.sv
package int4pack_pkg;

    localparam int IN_WIDTH       = 32;
    localparam int LANE_BITS      = 4;
    localparam int LANES_PER_WORD = 8;
    localparam int WORD_BITS      = LANE_BITS * LANES_PER_WORD;
    localparam int LANE_IDX_BITS  = $clog2(LANES_PER_WORD);

    typedef logic [LANE_BITS-1:0] nibble_t;

    typedef struct packed {
        logic [WORD_BITS-1:0] word;
        logic                 last;
    } beat_t;

endpackage

// File: rtl/nib_saturator.sv
module nib_saturator #(
    parameter int IN_W   = 32,
    parameter int LANE_W = 4
) (
    input  logic [IN_W-1:0]   value,
    output logic [LANE_W-1:0] nib
);
    localparam logic signed [IN_W-1:0] TOP_V = IN_W'((2 ** (LANE_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] BOT_V = ~TOP_V;

    logic signed [IN_W-1:0] sval;
    assign sval = value;

    always_comb begin
        if (sval > TOP_V) begin
            nib = TOP_V[LANE_W-1:0];
        end else if (sval < BOT_V) begin
            nib = BOT_V[LANE_W-1:0];
        end else begin
            nib = value[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/lane_assembler.sv
module lane_assembler #(
    parameter int LANE_W    = 4,
    parameter int NUM_LANES = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        take,
    input  logic [LANE_W-1:0]           nib,
    input  logic                        last_in,
    output logic                        done,
    output logic [LANE_W*NUM_LANES-1:0] word
);
    localparam int LIDX_W = $clog2(NUM_LANES);

    logic [NUM_LANES-1:0][LANE_W-1:0] acc_q;
    logic [NUM_LANES-1:0][LANE_W-1:0] merged;
    logic [LIDX_W-1:0]                lane_q;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign merged[g] = (lane_q == LIDX_W'(g)) ? nib : acc_q[g];
    end

    assign done = take && (last_in || (lane_q == LIDX_W'(NUM_LANES - 1)));
    assign word = merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            lane_q <= '0;
        end else if (done) begin
            acc_q  <= '0;
            lane_q <= '0;
        end else if (take) begin
            acc_q  <= merged;
            lane_q <= lane_q + LIDX_W'(1);
        end
    end
endmodule

// File: rtl/beat_holder.sv
module beat_holder
    import int4pack_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  beat_t load_beat,
    input  logic  pop_ready,
    output logic  valid,
    output beat_t beat,
    output logic  free
);
    logic  valid_q;
    beat_t beat_q;

    assign free  = !valid_q || pop_ready;
    assign valid = valid_q;
    assign beat  = beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            beat_q  <= load_beat;
        end else if (pop_ready) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/int4_lane_packer.sv
module int4_lane_packer
    import int4pack_pkg::*;
#(
    parameter int IN_W = IN_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [IN_W-1:0]      in_data,
    input  logic                 in_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_BITS-1:0] out_word,
    output logic                 out_last
);
    nibble_t              sat_nib;
    logic                 take;
    logic                 done;
    logic [WORD_BITS-1:0] asm_word;
    logic                 free;
    beat_t                new_beat;
    beat_t                held_beat;

    assign take     = in_valid && free;
    assign in_ready = free;
    assign new_beat = '{word: asm_word, last: in_last};

    nib_saturator #(.IN_W(IN_W), .LANE_W(LANE_BITS)) u_sat (
        .value (in_data),
        .nib   (sat_nib)
    );

    lane_assembler #(.LANE_W(LANE_BITS), .NUM_LANES(LANES_PER_WORD)) u_asm (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .nib     (sat_nib),
        .last_in (in_last),
        .done    (done),
        .word    (asm_word)
    );

    beat_holder u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (done),
        .load_beat (new_beat),
        .pop_ready (out_ready),
        .valid     (out_valid),
        .beat      (held_beat),
        .free      (free)
    );

    assign out_word = held_beat.word;
    assign out_last = held_beat.last;
endmodule

// File: rtl/int4_lane_packer_chk.sv
module int4_lane_packer_chk #(
    parameter int IN_W   = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [IN_W-1:0]   in_data,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic              out_last
);
    logic       acc;
    logic [3:0] cnt_q;
    logic [3:0] fill_q;
    logic       data_seen;

    assign acc       = in_valid && in_ready;
    assign data_seen = |in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= 4'd0;
            fill_q <= 4'd8;
        end else if (acc) begin
            if (cnt_q == 4'd7 || in_last) begin
                fill_q <= cnt_q + 4'd1;
                cnt_q  <= 4'd0;
            end else begin
                cnt_q <= cnt_q + 4'd1;
            end
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last));

    // R5
    flush_last_chk: assert property (@(posedge clk) disable iff (rst)
        acc && in_last |=> out_valid && out_last);

    // R4
    full_word_chk: assert property (@(posedge clk) disable iff (rst)
        acc && cnt_q == 4'd7 |=> out_valid && (out_last == $past(in_last)));

    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_word >> (fill_q * 4)) == '0));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid && in_ready);

    // R9
    ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);

    // R3
    any_data_chk: assert property (@(posedge clk) disable iff (rst)
        acc && data_seen && in_last |=> out_word != '0);
endmodule

bind int4_lane_packer int4_lane_packer_chk #(.IN_W(IN_W), .WORD_W(int4pack_pkg::WORD_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_last  (out_last)
);

// File: tb/sim_int4_lane_packer.sv
`timescale 1ns/100ps
module sim_int4_lane_packer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic        out_last;

    always #2.5 clk = ~clk;

    int4_lane_packer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .out_last(out_last)
    );

    int          total = 0;
    int          fails = 0;
    int          sv [0:511];
    bit          sl [0:511];
    int          n = 0;
    logic [31:0] ew [0:511];
    bit          el [0:511];
    int          ne = 0;
    logic [31:0] gw [0:511];
    bit          gl [0:511];
    int          ng = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] sat4(input int v);
        if (v > 7) return 4'h7;
        if (v < -8) return 4'h8;
        return v[3:0];
    endfunction

    task automatic push(input int v, input bit l);
        sv[n] = v;
        sl[n] = l;
        n++;
    endtask

    task automatic build_model();
        logic [31:0] acc = '0;
        int lane = 0;
        for (int i = 0; i < n; i++) begin
            acc = acc | (32'(sat4(sv[i])) << (4 * lane));
            lane++;
            if (lane == 8 || sl[i]) begin
                ew[ne] = acc;
                el[ne] = sl[i];
                ne++;
                acc = '0;
                lane = 0;
            end
        end
    endtask

    initial begin
        int          cyc;
        int          idx;
        bit          stall_prev;
        logic [31:0] stall_word;
        void'($urandom(32'd2024));

        // directed: saturation and full word (R1, R4)
        push(-1, 0); push(100, 0); push(-100, 0); push(3, 0);
        push(7, 0); push(-8, 0); push(8, 0); push(-9, 0);
        // partial flush (R5, R10)
        push(1, 0); push(2, 0); push(-3, 1);
        // last on lane 7 (R6, R3)
        for (int k = 0; k < 8; k++) push(k, k == 7);
        // single value with last (R2)
        push(-1, 1);
        // random phase
        for (int k = 0; k < 300; k++) begin
            int v;
            case ($urandom % 4)
                0: v = int'($urandom % 16) - 8;
                1: v = int'($urandom % 64) - 32;
                2: v = int'($urandom);
                default: v = (($urandom % 2) == 0) ? 8 : -9;
            endcase
            push(v, (k == 299) || (($urandom % 9) == 0));
        end
        build_model();

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R7 reset out_valid", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R7 reset in_ready", 32'(in_ready), 32'd1);

        cyc = 0;
        idx = 0;
        stall_prev = 0;
        stall_word = '0;
        while ((idx < n || ng < ne) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            out_ready = (idx < 20) ? 1'b1 : (($urandom % 10) < 7);
            if (idx < n) begin
                in_valid = 1'b1;
                in_data  = sv[idx];
                in_last  = sl[idx];
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (stall_prev) begin
                chk(out_valid && out_word == stall_word, "R8 hold", out_word, stall_word);
            end
            if (out_valid && !out_ready) begin
                chk(!in_ready, "R8 backpressure", 32'(in_ready), 32'd0);
            end
            if (idx < 20 && in_valid) begin
                chk(in_ready, "R9 throughput", 32'(in_ready), 32'd1);
            end
            stall_prev = out_valid && !out_ready;
            stall_word = out_word;
            if (out_valid && out_ready && ng < 512) begin
                gw[ng] = out_word;
                gl[ng] = out_last;
                ng++;
            end
            if (in_valid && in_ready) idx++;
        end
        if (cyc >= 20000) chk(1'b0, "watchdog", 32'(cyc), 32'd20000);

        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        #1;
        chk(!out_valid, "R6 no extra word", 32'(out_valid), 32'd0);
        chk(ng == ne, "R6 word count", 32'(ng), 32'(ne));

        chk(gw[0] == 32'h8787387F, "R1 saturation word", gw[0], 32'h8787387F);
        chk(gl[0] == 1'b0, "R4 full word last", 32'(gl[0]), 32'd0);
        chk(gw[1] == 32'h00000D21 && gl[1], "R10 fresh word after flush", gw[1], 32'h00000D21);
        chk(gw[2] == 32'h76543210, "R3 lane order", gw[2], 32'h76543210);
        chk(gl[2] == 1'b1, "R6 last on lane 7", 32'(gl[2]), 32'd1);
        chk(gw[3] == 32'h0000000F && gl[3], "R2 minus one nibble", gw[3], 32'h0000000F);
        for (int i = 0; i < ne && i < ng; i++) begin
            chk(gw[i] == ew[i], el[i] ? "R5 word" : "R4 word", gw[i], ew[i]);
            chk(gl[i] == el[i], "R5 last flag", 32'(gl[i]), 32'(el[i]));
        end

        // R7: reset discards a partial word
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 32'(k + 1);
            in_last  = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid && in_ready, "R7 mid reset", 32'(out_valid), 32'd0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'd5;
        in_last  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid && out_word == 32'h5 && out_last, "R7 partial discarded", out_word, 32'h5);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule